// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block lets a two-wire serial bus controller reach a bank of sixteen byte-wide registers inside the chip. It watches the clock and data lines through a synchronizer, recognises start, repeated start and stop conditions, and checks the 7-bit address against the address set by the `TGT_ADDR` parameter. It answers on the bus only by pulling a line low. The surrounding pad logic turns the two enable outputs into open-drain drivers.

In a write transaction, the first byte after the address selects a register, and each following byte is stored at the current pointer. To read, the controller first writes the pointer. It then issues a repeated start with the read direction bit and receives bytes until it answers with a NACK. Register contents are fetched through a read path with several cycles of latency. During that fetch the target holds the clock line low, so the controller waits for the data.

Top module: `twi_regfile_target`

## Requirements
- R1: After reset both line enables are released. The target drives neither line until it has seen a start condition (data falls while clock is high), and clocking a matching address without a start gets no ACK.
- R2: After a start, the target samples 8 bits MSB first on clock rising edges: 7 address bits and then a direction bit (1 = read). When the address equals `TGT_ADDR` (default 0x2A, so write byte 0x54 and read byte 0x55), it pulls data low for the ninth clock. Otherwise it leaves data released and ignores the bus until the next start.
- R3: The first byte after a write address is the register index. It is ACKed only when it is below 0x10. Otherwise it is NACKed and the rest of the transaction is ignored.
- R4: The target changes data only while the clock is low. Read bytes are sent MSB first.
- R5: Write data bytes aimed at indexes 0x00 to 0x0B are stored and ACKed. A byte aimed at 0x0C to 0x0F, or at the pointer value 0x10, is NACKed, leaves all registers unchanged and ends the transaction for the target.
- R6: Before each read byte, the target holds the clock low from the falling edge that precedes the byte until the fetched data is on the data line. The fetch takes `FETCH_CYC` system cycles.
- R7: A stop condition (data rises while clock is high) releases both lines and returns the target to idle from any state.
- R8: When the controller leaves the ninth bit of a read byte high (NACK), the target stops sending and keeps data released.
- R9: The pointer advances by one after every ACKed byte, whether written or read, and saturates at 0x10. Reading at 0x10 returns 0xFF.
- R10: The pointer is kept across repeated start and stop. A read with no index byte continues from the pointer that the last transaction left.
- R11: After reset, register i holds the byte formed by i in the upper nibble and the inverse of i in the lower nibble (register 3 = 0x3C, register 0x0F = 0xF0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| scl_oe | output | 1 | Pull the clock line low (stretching) |
| sda_oe | output | 1 | Pull the data line low (ACK or read data 0) |

## Verification
The hardest situation to reach is the read path at the edges of the pointer range. A burst has to cross from writable registers into read-only ones and then past the last index. Meanwhile every byte boundary must show the clock being held low while the controller is already trying to release it. The bench uses a bus model that releases the clock and then waits for the line to actually rise. It runs bursts that start at 0x0A and 0x0E with controller ACKs, so the pointer walks into saturation, and it records whether the clock was held low at the first bit of each byte. Repeated start and stop are placed mid-transaction to show that the pointer survives them and that idle is reached from the middle of a byte.

// File: rtl/twi_tgt_pkg.sv
package twi_tgt_pkg;

    localparam int REG_COUNT = 16;
    localparam int RO_FIRST  = 12;
    localparam int AW        = $clog2(REG_COUNT);
    localparam int IDX_W     = AW + 1;

    typedef logic [IDX_W-1:0] ptr_t;
    typedef logic [7:0]       byte_t;

    localparam ptr_t PTR_END  = ptr_t'(REG_COUNT);
    localparam ptr_t RO_START = ptr_t'(RO_FIRST);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RFETCH,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic byte_t reset_value(ptr_t i);
        return byte_t'({i[AW-1:0], ~i[AW-1:0]});
    endfunction

    function automatic ptr_t ptr_step(ptr_t p);
        return (p < PTR_END) ? ptr_t'(p + 1'b1) : p;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign sda_now = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
    import twi_tgt_pkg::*;
#(
    parameter int FETCH_CYC = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ptr_t  wr_idx,
    input  byte_t wr_data,
    input  logic  rd_req,
    input  ptr_t  rd_idx,
    output byte_t rd_data,
    output logic  rd_valid
);
    byte_t                mem [REG_COUNT];
    byte_t                rd_q;
    logic [FETCH_CYC-1:0] vpipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                mem[i] <= reset_value(ptr_t'(i));
            end
        end else if (wr_en && (wr_idx < RO_START)) begin
            mem[wr_idx[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_req) begin
            rd_q <= (rd_idx < PTR_END) ? mem[rd_idx[AW-1:0]] : 8'hFF;
        end
    end

    generate
        if (FETCH_CYC == 1) begin : g_short
            always_ff @(posedge clk) begin
                if (rst) vpipe <= '0;
                else     vpipe <= rd_req;
            end
        end else begin : g_long
            always_ff @(posedge clk) begin
                if (rst) vpipe <= '0;
                else     vpipe <= {vpipe[FETCH_CYC-2:0], rd_req};
            end
        end
    endgenerate

    assign rd_data  = rd_q;
    assign rd_valid = vpipe[FETCH_CYC-1];
endmodule

// File: rtl/twi_tgt_engine.sv
module twi_tgt_engine
    import twi_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h2A
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    input  byte_t    rd_data,
    input  logic     rd_valid,
    output logic     sda_oe,
    output logic     scl_oe,
    output logic     wr_en,
    output ptr_t     wr_idx,
    output byte_t    wr_data,
    output logic     rd_req,
    output ptr_t     rd_idx,
    output logic     busy,
    output ptr_t     ptr
);
    localparam byte_t IDX_LIMIT = byte_t'(REG_COUNT);

    tgt_state_e state;
    logic [3:0] cnt;
    byte_t      sreg;
    logic       dir_rd;
    logic       mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sreg   <= '0;
            dir_rd <= 1'b0;
            mack   <= 1'b0;
            ptr    <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
            wr_en  <= 1'b0;
            rd_req <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            rd_req <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INDEX, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            sreg <= {sreg[6:0], ev.sda};
                            cnt  <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (sreg[7:1] == TGT_ADDR) begin
                                    sda_oe <= 1'b1;
                                    dir_rd <= sreg[0];
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_INDEX) begin
                                if (sreg < IDX_LIMIT) begin
                                    sda_oe <= 1'b1;
                                    ptr    <= ptr_t'(sreg);
                                    state  <= ST_INDEX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                if (ptr < RO_START) begin
                                    sda_oe <= 1'b1;
                                    wr_en  <= 1'b1;
                                    state  <= ST_WDATA_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            if (dir_rd) begin
                                scl_oe <= 1'b1;
                                rd_req <= 1'b1;
                                state  <= ST_RFETCH;
                            end else begin
                                state <= ST_INDEX;
                            end
                        end
                    end
                    ST_INDEX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr_step(ptr);
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RFETCH: begin
                        if (rd_valid) begin
                            sreg   <= rd_data;
                            sda_oe <= ~rd_data[7];
                            cnt    <= 4'd1;
                            state  <= ST_RDATA;
                        end
                    end
                    ST_RDATA: begin
                        scl_oe <= 1'b0;
                        if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sreg   <= {sreg[6:0], 1'b0};
                                sda_oe <= ~sreg[6];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                ptr    <= ptr_step(ptr);
                                scl_oe <= 1'b1;
                                rd_req <= 1'b1;
                                state  <= ST_RFETCH;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign wr_idx  = ptr;
    assign wr_data = sreg;
    assign rd_idx  = ptr;
    assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/twi_regfile_target.sv
module twi_regfile_target
    import twi_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h2A,
    parameter int         FETCH_CYC   = 12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe
);
    line_ev_t ev;
    logic     wr_en;
    ptr_t     wr_idx;
    byte_t    wr_data;
    logic     rd_req;
    ptr_t     rd_idx;
    byte_t    rd_data;
    logic     rd_valid;
    logic     busy;
    ptr_t     ptr;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .ev     (ev)
    );

    twi_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx),
        .busy     (busy),
        .ptr      (ptr)
    );

    twi_regbank #(.FETCH_CYC(FETCH_CYC)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/twi_tgt_checker.sv
module twi_tgt_checker
    import twi_tgt_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input line_ev_t ev,
    input logic     sda_oe,
    input logic     scl_oe,
    input logic     wr_en,
    input ptr_t     wr_idx,
    input logic     busy,
    input ptr_t     ptr
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sda_oe && !scl_oe));

    p_sda_low_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    p_write_guard_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < RO_START));

    p_stretch_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> $past(ev.scl_fall));

    p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && !scl_oe));

    p_ptr_limit_r9: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_END);
endmodule

bind twi_regfile_target twi_tgt_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .sda_oe (sda_oe),
    .scl_oe (scl_oe),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .busy   (busy),
    .ptr    (ptr)
);

// File: tb/twi_regfile_target_tb.sv
module twi_regfile_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int WD_CYCLES  = 150000;
    localparam logic [7:0] AW_BYTE = 8'h54;
    localparam logic [7:0] AR_BYTE = 8'h55;

    typedef struct packed {
        logic       is_rd;
        logic [7:0] idx;
        logic [7:0] data;
        logic       idx_ok;
        logic       data_ok;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 8'h03, 8'h3C, 1'b1, 1'b1},
        '{1'b0, 8'h03, 8'h55, 1'b1, 1'b1},
        '{1'b1, 8'h03, 8'h55, 1'b1, 1'b1},
        '{1'b0, 8'h0D, 8'h99, 1'b1, 1'b0},
        '{1'b1, 8'h0D, 8'hD2, 1'b1, 1'b1},
        '{1'b0, 8'h0B, 8'hAA, 1'b1, 1'b1},
        '{1'b1, 8'h0B, 8'hAA, 1'b1, 1'b1},
        '{1'b0, 8'h12, 8'h44, 1'b0, 1'b0},
        '{1'b1, 8'h0F, 8'hF0, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_oe, sda_oe;
    logic scl_bus, sda_bus;
    int   checks = 0;
    int   errors = 0;

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_regfile_target u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_bus),
        .sda_i  (sda_bus),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b, output logic rb, output logic stretched);
        m_sda_low = !b;
        tick(H);
        m_scl_low = 1'b0;
        tick(1);
        stretched = !scl_bus;
        while (!scl_bus) tick(1);
        tick(H);
        rb = sda_bus;
        m_scl_low = 1'b1;
        tick(2);
    endtask

    task automatic do_start();
        m_sda_low = 1'b0;
        tick(H);
        m_scl_low = 1'b0;
        while (!scl_bus) tick(1);
        tick(H);
        m_sda_low = 1'b1;
        tick(H);
        m_scl_low = 1'b1;
        tick(H);
    endtask

    task automatic do_stop();
        m_sda_low = 1'b1;
        tick(H);
        m_scl_low = 1'b0;
        while (!scl_bus) tick(1);
        tick(H);
        m_sda_low = 1'b0;
        tick(H);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic rb, st;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], rb, st);
        clock_bit(1'b1, rb, st);
        ack = !rb;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] d, output logic str);
        logic rb, st;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, rb, st);
            d[i] = rb;
            if (i == 7) str = st;
        end
        clock_bit(!m_ack, rb, st);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       a;
        logic       rb;
        logic       st;
        logic [7:0] d;

        tick(5);
        rst = 1'b0;
        tick(3);
        check("R1 reset sda", {31'd0, sda_oe}, 32'd0);
        check("R1 reset scl", {31'd0, scl_oe}, 32'd0);

        // R1: address clocked without a start gets no ACK
        m_scl_low = 1'b1;
        tick(H);
        write_byte(AW_BYTE, a);
        check("R1 no start no ack", {31'd0, a}, 32'd0);
        m_sda_low = 1'b0;
        tick(H);
        m_scl_low = 1'b0;
        tick(H);

        // table walk: R2 R3 R4 R5 R11
        for (int v = 0; v < 9; v++) begin
            do_start();
            write_byte(AW_BYTE, a);
            check("R2 addr ack", {31'd0, a}, 32'd1);
            write_byte(VECS[v].idx, a);
            check("R3 index ack", {31'd0, a}, {31'd0, VECS[v].idx_ok});
            if (VECS[v].is_rd) begin
                do_start();
                write_byte(AR_BYTE, a);
                check("R2 read addr ack", {31'd0, a}, 32'd1);
                read_byte(1'b0, d, st);
                check("R11 R4 read data", {24'd0, d}, {24'd0, VECS[v].data});
            end else begin
                write_byte(VECS[v].data, a);
                check("R5 R3 data ack", {31'd0, a}, {31'd0, VECS[v].data_ok});
            end
            do_stop();
        end

        // R2: mismatched address NACKed and rest ignored
        do_start();
        write_byte(8'h22, a);
        check("R2 mismatch nack", {31'd0, a}, 32'd0);
        write_byte(8'h00, a);
        check("R2 ignored after mismatch", {31'd0, a}, 32'd0);
        do_stop();

        // R5 R9: burst write walks into read-only area
        do_start();
        write_byte(AW_BYTE, a);
        write_byte(8'h0A, a);
        write_byte(8'h11, a);
        check("R9 burst ack 0x0A", {31'd0, a}, 32'd1);
        write_byte(8'h22, a);
        check("R9 burst ack 0x0B", {31'd0, a}, 32'd1);
        write_byte(8'h33, a);
        check("R5 burst nack 0x0C", {31'd0, a}, 32'd0);
        do_stop();

        // R6 R9: burst read with stretching
        do_start();
        write_byte(AW_BYTE, a);
        write_byte(8'h0A, a);
        do_start();
        write_byte(AR_BYTE, a);
        read_byte(1'b1, d, st);
        check("R9 burst rd 0x0A", {24'd0, d}, 32'h11);
        check("R6 stretch first byte", {31'd0, st}, 32'd1);
        read_byte(1'b1, d, st);
        check("R9 burst rd 0x0B", {24'd0, d}, 32'h22);
        check("R6 stretch next byte", {31'd0, st}, 32'd1);
        read_byte(1'b1, d, st);
        check("R5 R9 burst rd 0x0C unchanged", {24'd0, d}, 32'hC3);
        read_byte(1'b0, d, st);
        check("R9 burst rd 0x0D", {24'd0, d}, 32'hD2);
        do_stop();

        // R9: saturation at 0x10, R8: NACK ends the read
        do_start();
        write_byte(AW_BYTE, a);
        write_byte(8'h0E, a);
        do_start();
        write_byte(AR_BYTE, a);
        read_byte(1'b1, d, st);
        check("R9 rd 0x0E", {24'd0, d}, 32'hE1);
        read_byte(1'b1, d, st);
        check("R9 rd 0x0F", {24'd0, d}, 32'hF0);
        read_byte(1'b1, d, st);
        check("R9 rd past end", {24'd0, d}, 32'hFF);
        read_byte(1'b0, d, st);
        check("R9 rd saturated", {24'd0, d}, 32'hFF);
        tick(H);
        check("R8 sda released after nack", {31'd0, sda_oe}, 32'd0);
        clock_bit(1'b1, rb, st);
        check("R8 no drive after nack", {31'd0, rb}, 32'd1);
        check("R8 no stretch after nack", {31'd0, st}, 32'd0);
        do_stop();

        // R10: pointer kept across stop, read without index
        do_start();
        write_byte(AW_BYTE, a);
        write_byte(8'h05, a);
        write_byte(8'h77, a);
        do_stop();
        do_start();
        write_byte(AR_BYTE, a);
        read_byte(1'b0, d, st);
        check("R10 read continues at ptr 6", {24'd0, d}, 32'h69);
        do_stop();

        // R7: stop in the middle of a byte
        do_start();
        write_byte(AW_BYTE, a);
        write_byte(8'h02, a);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, rb, st);
        do_stop();
        tick(4);
        check("R7 sda released after stop", {31'd0, sda_oe}, 32'd0);
        check("R7 scl released after stop", {31'd0, scl_oe}, 32'd0);
        m_scl_low = 1'b1;
        tick(H);
        write_byte(AW_BYTE, a);
        check("R7 idle ignores bytes after stop", {31'd0, a}, 32'd0);
        m_sda_low = 1'b0;
        tick(H);
        m_scl_low = 1'b0;
        tick(H);
        do_start();
        write_byte(AR_BYTE, a);
        read_byte(1'b0, d, st);
        check("R7 R10 read after aborted write", {24'd0, d}, 32'h2D);
        do_stop();

        finish_run();
    end
endmodule